// File: doc/BRIEF.md
# IR Pulse/Space Packet Stream Parser

This block sits behind an infrared receiver buffer and splits its byte stream into packets. Each packet starts with a header byte. A header either announces a short run of run-length samples, with the count carried inline, or opens a command. A command is followed by a sub-command byte, and the pair sets how many payload bytes come after it. The parser walks four states: header, sub-command, command payload and sample. It keeps a count of the bytes still owed to the current packet.

Every sample byte produces a one-cycle strobe carrying a level flag and a duration in microseconds. A sample header with a count of zero produces a one-cycle reset-event strobe. When a command packet finishes, a one-cycle strobe reports its command and sub-command codes.

The input is a valid/ready stream. The parser never stalls on data. `in_ready` is low only while `flush` is high, and a byte is consumed in exactly the cycles where `in_valid` and `in_ready` are both high. The output strobes have no back-pressure, so the consumer must take each one in the cycle it appears. Every output appears one clock after the byte that caused it is accepted.

Top module: `ir_pkt_parser`

## Requirements
- R1: After reset, all strobes are low, the reported command and sub-command codes are 0x00, and the first accepted byte is treated as a header.
- R2: In the header state, the byte 0x9F is a command byte, and so is any byte whose bits 7:5 are not 100b. The byte after a command byte is its sub-command.
- R3: Any other header byte carries, in bits 4:0, the number of sample bytes that follow it.
- R4: A sample header whose bits 4:0 are zero raises `evt_reset` for one cycle and leaves the parser in the header state.
- R5: The number of payload bytes after a sub-command is set by the command and sub-command pair:
  - command 0x9F: two bytes for sub-commands 0x06, 0x0C and 0x15, and one byte for 0x01, 0x08 and 0x14;
  - command 0x00 with sub-command 0xFF: one byte;
  - command 0xFF with sub-command 0x0B: two bytes;
  - every other pair: zero bytes.
- R6: For a sample byte, `smp_pulse` is bit 7 (1 = pulse, 0 = space), and `smp_dur_us` is bits 6:0 multiplied by 50.
- R7: Each payload or sample byte takes one from the remaining count. When the count reaches zero, the next byte is a header.
- R8: A pair with zero payload bytes completes at the sub-command byte, and the byte after it is a header.
- R9: `cmd_done` rises for one cycle when a command packet completes. It comes with `cmd_code` and `cmd_sub`, which hold their values until the next completion.
- R10: While `flush` is high, `in_ready` is low and no byte is consumed. After the flush, the parser is in the header state with a remaining count of zero.
- R11: A cycle with no accepted byte changes no parser state and raises no strobe.
- R12: At most one of `smp_valid`, `evt_reset` and `cmd_done` is high in any cycle, and each is high for a single cycle per byte.
- R13: Every strobe is raised in the cycle right after the accepting clock edge of the byte that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous return to the header state |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Parser accepts a byte (low during flush) |
| in_byte | input | 8 | Input byte |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_pulse | output | 1 | Sample level: 1 = pulse, 0 = space |
| smp_dur_us | output | 13 | Sample duration in microseconds |
| evt_reset | output | 1 | One-cycle strobe for an empty sample packet |
| cmd_done | output | 1 | One-cycle command-complete strobe |
| cmd_code | output | 8 | Command code of the last completed command |
| cmd_sub | output | 8 | Sub-command code of the last completed command |

## Verification
The hardest situations to reach from the ports are the ones where a byte's meaning depends only on hidden framing state. Examples are a payload byte of 0x9F, which must not open a new command, and a flush that lands partway through a sample run. Neither is visible at the outputs when it happens. The stimulus first drives a continuous stream in which command payloads reuse header-like values and zero-length pairs are followed straight away by sample headers. It then flushes or resets in the middle of a packet and sends 0x80. Only a parser that really returned to the header state answers that byte with a reset event rather than a sample.

// File: rtl/ir_pkt_pkg.sv
package ir_pkt_pkg;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_SUB  = 2'd1,
    ST_DATA = 2'd2,
    ST_SAMP = 2'd3
  } parse_st_e;

  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 5;
  localparam int SMP_W   = 7;
  localparam int PLEN_W  = 2;

  localparam logic [BYTE_W-1:0] OP_ESCAPE = 8'h9F;
  localparam logic [BYTE_W-1:0] OP_NULL   = 8'h00;
  localparam logic [BYTE_W-1:0] OP_HWCMD  = 8'hFF;
  localparam logic [2:0]        SMP_TAG   = 3'b100;

endpackage

// File: rtl/ir_hdr_classify.sv
module ir_hdr_classify
  import ir_pkt_pkg::*;
(
  input  logic [BYTE_W-1:0] hdr_byte,
  output logic              is_cmd,
  output logic [CNT_W-1:0]  inline_cnt
);
  always_comb begin
    is_cmd     = (hdr_byte == OP_ESCAPE) || (hdr_byte[7:5] != SMP_TAG);
    inline_cnt = hdr_byte[CNT_W-1:0];
  end
endmodule

// File: rtl/ir_cmd_len.sv
module ir_cmd_len
  import ir_pkt_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  logic [BYTE_W-1:0] sub,
  output logic [PLEN_W-1:0] plen
);
  always_comb begin
    plen = '0;
    unique case (op)
      OP_NULL:   if (sub == 8'hFF) plen = 2'd1;
      OP_HWCMD:  if (sub == 8'h0B) plen = 2'd2;
      OP_ESCAPE: begin
        case (sub)
          8'h06, 8'h0C, 8'h15: plen = 2'd2;
          8'h01, 8'h08, 8'h14: plen = 2'd1;
          default:             plen = 2'd0;
        endcase
      end
      default:   plen = '0;
    endcase
  end
endmodule

// File: rtl/ir_dur_scale.sv
module ir_dur_scale
  import ir_pkt_pkg::*;
#(
  parameter int UNIT_US = 50,
  parameter int DUR_W   = 13
) (
  input  logic [SMP_W-1:0] ticks,
  output logic [DUR_W-1:0] dur_us
);
  localparam logic [DUR_W-1:0] UNIT_V = DUR_W'(UNIT_US);
  always_comb dur_us = DUR_W'(ticks) * UNIT_V;
endmodule

// File: rtl/ir_pkt_parser.sv
module ir_pkt_parser
  import ir_pkt_pkg::*;
#(
  parameter int UNIT_US = 50,
  parameter int DUR_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              smp_valid,
  output logic              smp_pulse,
  output logic [DUR_W-1:0]  smp_dur_us,
  output logic              evt_reset,
  output logic              cmd_done,
  output logic [7:0]        cmd_code,
  output logic [7:0]        cmd_sub
);
  localparam int MAX_DUR = ((1 << SMP_W) - 1) * UNIT_US;

  parse_st_e            st_q;
  logic [CNT_W-1:0]     rem_q;
  logic [BYTE_W-1:0]    op_q, sub_q;
  logic                 take;
  logic                 hdr_is_cmd;
  logic [CNT_W-1:0]     hdr_cnt;
  logic [PLEN_W-1:0]    plen;
  logic [DUR_W-1:0]     dur_now;

  assign in_ready = !flush;
  assign take     = in_valid && in_ready;

  ir_hdr_classify u_cls (
    .hdr_byte   (in_byte),
    .is_cmd     (hdr_is_cmd),
    .inline_cnt (hdr_cnt)
  );

  ir_cmd_len u_len (
    .op   (op_q),
    .sub  (in_byte),
    .plen (plen)
  );

  ir_dur_scale #(.UNIT_US(UNIT_US), .DUR_W(DUR_W)) u_dur (
    .ticks  (in_byte[SMP_W-1:0]),
    .dur_us (dur_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_HDR;
      rem_q      <= '0;
      op_q       <= '0;
      sub_q      <= '0;
      smp_valid  <= 1'b0;
      smp_pulse  <= 1'b0;
      smp_dur_us <= '0;
      evt_reset  <= 1'b0;
      cmd_done   <= 1'b0;
      cmd_code   <= '0;
      cmd_sub    <= '0;
    end else begin
      smp_valid <= 1'b0;
      evt_reset <= 1'b0;
      cmd_done  <= 1'b0;
      if (flush) begin
        st_q  <= ST_HDR;
        rem_q <= '0;
      end else if (take) begin
        unique case (st_q)
          ST_HDR: begin
            if (hdr_is_cmd) begin
              op_q <= in_byte;
              st_q <= ST_SUB;
            end else if (hdr_cnt == '0) begin
              evt_reset <= 1'b1;
            end else begin
              rem_q <= hdr_cnt;
              st_q  <= ST_SAMP;
            end
          end
          ST_SUB: begin
            sub_q <= in_byte;
            if (plen == '0) begin
              cmd_done <= 1'b1;
              cmd_code <= op_q;
              cmd_sub  <= in_byte;
              st_q     <= ST_HDR;
            end else begin
              rem_q <= CNT_W'(plen);
              st_q  <= ST_DATA;
            end
          end
          ST_DATA: begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) begin
              cmd_done <= 1'b1;
              cmd_code <= op_q;
              cmd_sub  <= sub_q;
              st_q     <= ST_HDR;
            end
          end
          ST_SAMP: begin
            rem_q      <= rem_q - 1'b1;
            smp_valid  <= 1'b1;
            smp_pulse  <= in_byte[7];
            smp_dur_us <= dur_now;
            if (rem_q == CNT_W'(1)) st_q <= ST_HDR;
          end
          default: st_q <= ST_HDR;
        endcase
      end
    end
  end

  // R12: strobes never overlap
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smp_valid, evt_reset, cmd_done}));

  // R11: no accepted byte, no strobe next cycle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !(smp_valid || evt_reset || cmd_done));

  // R10: flush lands in header with empty count
  a_r10_flush_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (st_q == ST_HDR) && (rem_q == '0));

  // R7: payload and sample states always owe at least one byte
  a_r7_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA || st_q == ST_SAMP) |-> (rem_q != '0));

  // R6: durations are whole units within range
  a_r6_dur_units: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ((int'(smp_dur_us) % UNIT_US) == 0) && (int'(smp_dur_us) <= MAX_DUR));

  // R4: reset event only from a header byte
  a_r4_evt_from_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reset |-> ($past(st_q) == ST_HDR) && $past(in_valid));

  // R9: command completes from sub-command or payload state
  a_r9_done_src: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> ($past(st_q) == ST_SUB || $past(st_q) == ST_DATA));

  // R13: sample strobe follows an accepted sample byte
  a_r13_smp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ($past(st_q) == ST_SAMP) && $past(in_valid) && !$past(flush));

endmodule

// File: tb/ir_pkt_parser_test.sv
module ir_pkt_parser_test;
  localparam int NV = 48;
  localparam logic [1:0] K_N = 2'd0, K_S = 2'd1, K_R = 2'd2, K_C = 2'd3;

  // {byte, kind, pulse, dur, code, sub}
  localparam logic [39:0] VEC [NV] = '{
    {8'h83, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h8A, K_S, 1'b1, 13'd500,  8'h00, 8'h00},
    {8'h05, K_S, 1'b0, 13'd250,  8'h00, 8'h00},
    {8'hFF, K_S, 1'b1, 13'd6350, 8'h00, 8'h00},
    {8'h80, K_R, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h9F, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h06, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h12, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h34, K_C, 1'b0, 13'd0,    8'h9F, 8'h06},
    {8'h9F, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h01, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'hAB, K_C, 1'b0, 13'd0,    8'h9F, 8'h01},
    {8'h9F, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h22, K_C, 1'b0, 13'd0,    8'h9F, 8'h22},
    {8'h81, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h00, K_S, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h00, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'hFF, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h9F, K_C, 1'b0, 13'd0,    8'h00, 8'hFF},
    {8'hFF, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h0B, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h80, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h81, K_C, 1'b0, 13'd0,    8'hFF, 8'h0B},
    {8'h40, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h0B, K_C, 1'b0, 13'd0,    8'h40, 8'h0B},
    {8'h9F, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h0C, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h01, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h02, K_C, 1'b0, 13'd0,    8'h9F, 8'h0C},
    {8'h9F, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h15, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h00, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h00, K_C, 1'b0, 13'd0,    8'h9F, 8'h15},
    {8'h9F, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h08, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h55, K_C, 1'b0, 13'd0,    8'h9F, 8'h08},
    {8'h9F, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h14, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h66, K_C, 1'b0, 13'd0,    8'h9F, 8'h14},
    {8'h00, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h0B, K_C, 1'b0, 13'd0,    8'h00, 8'h0B},
    {8'hFF, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'hFF, K_C, 1'b0, 13'd0,    8'hFF, 8'hFF},
    {8'hA0, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'h06, K_C, 1'b0, 13'd0,    8'hA0, 8'h06},
    {8'h82, K_N, 1'b0, 13'd0,    8'h00, 8'h00},
    {8'hC0, K_S, 1'b1, 13'd3200, 8'h00, 8'h00},
    {8'h7F, K_S, 1'b0, 13'd6350, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = 8'h00;
  logic smp_valid, smp_pulse, evt_reset, cmd_done;
  logic [12:0] smp_dur_us;
  logic [7:0] cmd_code, cmd_sub;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ir_pkt_parser uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .smp_valid(smp_valid),
    .smp_pulse(smp_pulse), .smp_dur_us(smp_dur_us), .evt_reset(evt_reset),
    .cmd_done(cmd_done), .cmd_code(cmd_code), .cmd_sub(cmd_sub)
  );

  task automatic check(input string req, input logic [1:0] kind, input logic pulse,
                       input logic [12:0] dur, input logic [7:0] code, input logic [7:0] sub);
    logic ok;
    n_chk++;
    ok = (smp_valid == (kind == K_S)) && (evt_reset == (kind == K_R)) &&
         (cmd_done == (kind == K_C));
    if (kind == K_S) ok = ok && (smp_pulse == pulse) && (smp_dur_us == dur);
    if (kind == K_C) ok = ok && (cmd_code == code) && (cmd_sub == sub);
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got s=%0b r=%0b c=%0b p=%0b d=%0d code=%h sub=%h exp kind=%0d p=%0b d=%0d code=%h sub=%h",
               req, smp_valid, evt_reset, cmd_done, smp_pulse, smp_dur_us, cmd_code, cmd_sub,
               kind, pulse, dur, code, sub);
    end
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #2;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    n_chk++;
    if (smp_valid || evt_reset || cmd_done || !in_ready || cmd_code != 8'h00 || cmd_sub != 8'h00) begin
      n_bad++;
      $display("FAIL R1: strobes=%0b%0b%0b ready=%0b code=%h sub=%h exp 000 1 00 00",
               smp_valid, evt_reset, cmd_done, in_ready, cmd_code, cmd_sub);
    end

    // R2 R3 R5 R6 R7 R8 R9 R13: streamed table
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][39:32]);
      check("R2/R3/R5/R6/R7/R8/R9/R13 table", VEC[i][31:30], VEC[i][29], VEC[i][28:16],
            VEC[i][15:8], VEC[i][7:0]);
    end

    // R12: strobe lasts one cycle; R9: codes held
    push(8'h80);
    check("R4 empty header", K_R, 1'b0, 13'd0, 8'h00, 8'h00);
    idle(1);
    check("R12 single-cycle strobe", K_N, 1'b0, 13'd0, 8'h00, 8'h00);
    n_chk++;
    if (cmd_code != 8'hA0 || cmd_sub != 8'h06) begin
      n_bad++;
      $display("FAIL R9 held codes: got %h/%h exp a0/06", cmd_code, cmd_sub);
    end

    // R11: idle cycles with changing byte inside a sample run
    push(8'h82);
    in_byte = 8'h80;
    idle(1);
    check("R11 idle no strobe", K_N, 1'b0, 13'd0, 8'h00, 8'h00);
    in_byte = 8'h9F;
    idle(2);
    check("R11 idle no strobe", K_N, 1'b0, 13'd0, 8'h00, 8'h00);
    push(8'h83);
    check("R11 run intact", K_S, 1'b1, 13'd150, 8'h00, 8'h00);
    push(8'h01);
    check("R11 run intact", K_S, 1'b0, 13'd50, 8'h00, 8'h00);
    push(8'h80);
    check("R7 back to header", K_R, 1'b0, 13'd0, 8'h00, 8'h00);

    // R10: flush inside a sample run, byte offered during flush is ignored
    push(8'h85);
    push(8'h81);
    check("R10 pre-flush sample", K_S, 1'b1, 13'd50, 8'h00, 8'h00);
    flush = 1'b1; in_valid = 1'b1; in_byte = 8'h80;
    #1;
    n_chk++;
    if (in_ready !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 ready during flush: got %0b exp 0", in_ready);
    end
    @(posedge clk); #2;
    flush = 1'b0; in_valid = 1'b0;
    check("R10 flush no strobe", K_N, 1'b0, 13'd0, 8'h00, 8'h00);
    push(8'h80);
    check("R10 header after flush", K_R, 1'b0, 13'd0, 8'h00, 8'h00);

    // R10: flush inside a command payload
    push(8'h9F); push(8'h06); push(8'h11);
    flush = 1'b1; idle(1); flush = 1'b0;
    push(8'h80);
    check("R10 flush in payload", K_R, 1'b0, 13'd0, 8'h00, 8'h00);

    // R1: reset inside a sample run
    push(8'h84);
    rst_n = 1'b0; idle(1); rst_n = 1'b1; idle(1);
    push(8'h80);
    check("R1 header after reset", K_R, 1'b0, 13'd0, 8'h00, 8'h00);
    n_chk++;
    if (cmd_code != 8'h00) begin
      n_bad++;
      $display("FAIL R1 code after reset: got %h exp 00", cmd_code);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule